// File: doc/BRIEF.md
# Selector-Fed Arithmetic Unit

This block is a purely combinational arithmetic unit of parameterised width. It has one chain of full adders. Every stage adds a bit of operand A to a second-operand bit taken from a small per-bit selector. That selector offers the bit of B, its inverse, a constant 0 or a constant 1. A two-bit operation select picks the selector input, and the carry input turns each choice into one of two operations. Together they give add, add with carry, subtract, subtract with borrow, increment, decrement and two forms of pass-through of A.

A surrounding datapath drives the operands, the select and the carry input from its own registers. It captures the result word and the carry that leaves the most significant stage. The unit holds no state and has no clock.

Top module: `amu_arith_unit`

## Requirements
- R1: The select code picks the second operand Y bit by bit: 2'b00 gives Y = B, 2'b01 gives Y = ~B, 2'b10 gives Y = all zeros, and 2'b11 gives Y = all ones. In every mode the outputs satisfy {carry_out, d_out} = A + Y + carry_in, computed at WIDTH+1 bits.
- R2: With select 2'b00, {carry_out, d_out} equals A + B with carry_in = 0 (add) and A + B + 1 with carry_in = 1 (add with carry).
- R3: With select 2'b01 and carry_in = 1, d_out equals A - B modulo 2^WIDTH and carry_out is 1 exactly when A >= B (unsigned).
- R4: With select 2'b01 and carry_in = 0, d_out equals A - B - 1 modulo 2^WIDTH and carry_out is 1 exactly when A > B (unsigned).
- R5: With select 2'b10, carry_in = 0 passes A to d_out with carry_out = 0. Carry_in = 1 gives A + 1, with carry_out = 1 only when A is all ones.
- R6: With select 2'b11, carry_in = 0 gives A - 1 with carry_out = 1 exactly when A is nonzero. Carry_in = 1 passes A to d_out with carry_out = 1.
- R7: Decrement of zero (select 2'b11, carry_in = 0, A = 0) gives d_out all ones and carry_out = 0.
- R8: In add mode carry_out is the unsigned overflow of A + B + carry_in. A carry entering stage 0 ripples through every stage: A all ones, B zero and carry_in = 1 give d_out = 0 and carry_out = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A, always the first adder input |
| b_in | input | WIDTH | Operand B, offered to the selector straight and inverted |
| op_sel | input | 2 | Operation select choosing the selector input |
| carry_in | input | 1 | Carry into stage 0, acting as operation modifier |
| d_out | output | WIDTH | Result word |
| carry_out | output | 1 | Carry out of the most significant stage |

## Verification
Each select code is driven with both carry-input values over a pseudo-random operand stream. The bench compares against reference arithmetic at WIDTH+1 bits, so a wrong selector input shows up in the result word while a wrong carry polarity shows up in carry_out. Directed corners are added on top: zero and all-ones operands, equal operands and operands differing by one in subtraction. These separate the A >= B and A > B borrow boundaries, the wrap of increment and decrement, and a carry that must cross every stage.

// File: rtl/amu_pkg.sv
package amu_pkg;

   typedef enum logic [1:0] {
      AMU_Y_B    = 2'b00,
      AMU_Y_NB   = 2'b01,
      AMU_Y_ZERO = 2'b10,
      AMU_Y_ONES = 2'b11
   } amu_ysel_e;

   localparam int AMU_SEL_W = 2;

   function automatic logic amu_pick_bit(input amu_ysel_e s, input logic b);
      case (s)
         AMU_Y_B:    amu_pick_bit = b;
         AMU_Y_NB:   amu_pick_bit = ~b;
         AMU_Y_ZERO: amu_pick_bit = 1'b0;
         default:    amu_pick_bit = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/amu_operand_sel.sv
module amu_operand_sel
   import amu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]     b_word,
   input  logic [AMU_SEL_W-1:0] sel,
   output logic [WIDTH-1:0]     y_word
);

   localparam int LAST = WIDTH - 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("amu_operand_sel: WIDTH must be at least 1");
   end

   amu_ysel_e sel_e;
   assign sel_e = amu_ysel_e'(sel);

   for (genvar i = 0; i <= LAST; i++) begin : g_bit
      logic y_bit;
      always_comb begin
         y_bit = amu_pick_bit(sel_e, b_word[i]);
      end
      assign y_word[i] = y_bit;
   end

   always_comb begin
      case (sel_e)
         AMU_Y_B:    assert_ysel_b_R1:    assert (y_word == b_word);
         AMU_Y_NB:   assert_ysel_nb_R1:   assert (y_word == ~b_word);
         AMU_Y_ZERO: assert_ysel_zero_R1: assert (y_word == '0);
         default:    assert_ysel_ones_R1: assert (y_word == '1);
      endcase
   end

endmodule

// File: rtl/amu_full_adder.sv
module amu_full_adder (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);

   logic half;
   assign half = x ^ y;
   assign s    = half ^ ci;
   assign co   = (x & y) | (half & ci);

   always_comb begin
      assert_fa_sum_R1: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {1'b0, ci}));
   end

endmodule

// File: rtl/amu_ripple_chain.sv
module amu_ripple_chain #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x_word,
   input  logic [WIDTH-1:0] y_word,
   input  logic             c_first,
   output logic [WIDTH-1:0] s_word,
   output logic             c_last
);

   localparam int NCARRY = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("amu_ripple_chain: WIDTH must be at least 1");
   end

   logic [NCARRY-1:0] carry;
   assign carry[0] = c_first;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      amu_full_adder u_fa (
         .x  (x_word[i]),
         .y  (y_word[i]),
         .ci (carry[i]),
         .s  (s_word[i]),
         .co (carry[i+1])
      );
   end

   assign c_last = carry[NCARRY-1];

   always_comb begin
      assert_chain_sum_R8: assert ({c_last, s_word} ==
                                   ({1'b0, x_word} + {1'b0, y_word} + {{WIDTH{1'b0}}, c_first}));
   end

endmodule

// File: rtl/amu_arith_unit.sv
module amu_arith_unit
   import amu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [1:0]       op_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] d_out,
   output logic             carry_out
);

   localparam int EXT_W = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("amu_arith_unit: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] y_word;

   amu_operand_sel #(.WIDTH(WIDTH)) u_sel (
      .b_word (b_in),
      .sel    (op_sel),
      .y_word (y_word)
   );

   amu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
      .x_word  (a_in),
      .y_word  (y_word),
      .c_first (carry_in),
      .s_word  (d_out),
      .c_last  (carry_out)
   );

   logic [EXT_W-1:0] a_ext, b_ext, c_ext, nb_ext;
   assign a_ext  = {1'b0, a_in};
   assign b_ext  = {1'b0, b_in};
   assign nb_ext = {1'b0, ~b_in};
   assign c_ext  = {{WIDTH{1'b0}}, carry_in};

   always_comb begin
      case (op_sel)
         2'b00: begin
            assert_add_R2: assert ({carry_out, d_out} == a_ext + b_ext + c_ext);
         end
         2'b01: begin
            if (carry_in) begin
               assert_sub_R3: assert (d_out == WIDTH'(a_in - b_in) && carry_out == (a_in >= b_in));
            end else begin
               assert_subb_R4: assert (d_out == WIDTH'(a_in - b_in - 1'b1) && carry_out == (a_in > b_in));
            end
         end
         2'b10: begin
            assert_inc_R5: assert ({carry_out, d_out} == a_ext + c_ext);
         end
         default: begin
            if (carry_in) begin
               assert_pass_R6: assert (d_out == a_in && carry_out);
            end else begin
               assert_dec_R6: assert (d_out == WIDTH'(a_in - 1'b1) && carry_out == (a_in != '0));
               if (a_in == '0) begin
                  assert_dec_zero_R7: assert (d_out == '1 && !carry_out);
               end
            end
         end
      endcase
   end

endmodule

// File: tb/sim_amu_arith_unit.sv
module sim_amu_arith_unit;

   localparam int W = 8;
   localparam int M = W + 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] a, b, d;
   logic [1:0]   sel;
   logic         cin, cout;

   int checks = 0;
   int errors = 0;
   logic [31:0] lfsr = 32'hACE1_1234;

   amu_arith_unit #(.WIDTH(W)) u0 (
      .a_in(a), .b_in(b), .op_sel(sel), .carry_in(cin),
      .d_out(d), .carry_out(cout)
   );

   task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: a=%0h b=%0h sel=%0b cin=%0b got=%0h expected=%0h",
                  req, a, b, sel, cin, got, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic [1:0] s, input logic c);
      @(posedge clk);
      #5;
      a = av; b = bv; sel = s; cin = c;
      #5;
   endtask

   function automatic logic [W-1:0] ref_y(input logic [1:0] s, input logic [W-1:0] bv);
      case (s)
         2'b00: ref_y = bv;
         2'b01: ref_y = ~bv;
         2'b10: ref_y = '0;
         default: ref_y = '1;
      endcase
   endfunction

   function automatic logic [W-1:0] rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rnd = lfsr[W-1:0] ^ lfsr[W+7:8];
   endfunction

   // R1: every code and carry on random operands against A + Y + Cin
   task automatic t_random_all_modes();
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 150; k++) begin
               logic [W-1:0] av, bv;
               av = rnd(); bv = rnd();
               apply(av, bv, 2'(s), 1'(c));
               check("R1", {cout, d}, {1'b0, av} + {1'b0, ref_y(2'(s), bv)} + M'(c));
            end
         end
      end
   endtask

   // R2 and R8: add, add with carry, overflow and full ripple
   task automatic t_add();
      apply(8'd23, 8'd19, 2'b00, 1'b0); check("R2", {cout, d}, 9'd42);
      apply(8'd23, 8'd19, 2'b00, 1'b1); check("R2", {cout, d}, 9'd43);
      apply(8'hF0, 8'h20, 2'b00, 1'b0); check("R8", {cout, d}, 9'h110);
      apply(8'hFF, 8'h00, 2'b00, 1'b1); check("R8", {cout, d}, 9'h100);
      apply(8'hFF, 8'hFF, 2'b00, 1'b1); check("R8", {cout, d}, 9'h1FF);
      apply(8'h7F, 8'h80, 2'b00, 1'b0); check("R8", {cout, d}, 9'h0FF);
   endtask

   // R3 and R4: subtraction boundaries
   task automatic t_sub();
      apply(8'd50, 8'd50, 2'b01, 1'b1); check("R3", {cout, d}, {1'b1, 8'd0});
      apply(8'd49, 8'd50, 2'b01, 1'b1); check("R3", {cout, d}, {1'b0, 8'hFF});
      apply(8'd90, 8'd30, 2'b01, 1'b1); check("R3", {cout, d}, {1'b1, 8'd60});
      apply(8'd50, 8'd50, 2'b01, 1'b0); check("R4", {cout, d}, {1'b0, 8'hFF});
      apply(8'd51, 8'd50, 2'b01, 1'b0); check("R4", {cout, d}, {1'b1, 8'd0});
      apply(8'd0,  8'hFF, 2'b01, 1'b0); check("R4", {cout, d}, {1'b0, 8'd0});
   endtask

   // R5: transfer and increment
   task automatic t_pass_inc();
      apply(8'h5A, 8'hC3, 2'b10, 1'b0); check("R5", {cout, d}, {1'b0, 8'h5A});
      apply(8'h5A, 8'hC3, 2'b10, 1'b1); check("R5", {cout, d}, {1'b0, 8'h5B});
      apply(8'hFF, 8'h00, 2'b10, 1'b1); check("R5", {cout, d}, {1'b1, 8'h00});
      apply(8'hFF, 8'h12, 2'b10, 1'b0); check("R5", {cout, d}, {1'b0, 8'hFF});
   endtask

   // R6 and R7: decrement and second transfer
   task automatic t_dec_pass();
      apply(8'h40, 8'h77, 2'b11, 1'b0); check("R6", {cout, d}, {1'b1, 8'h3F});
      apply(8'h40, 8'h77, 2'b11, 1'b1); check("R6", {cout, d}, {1'b1, 8'h40});
      apply(8'h00, 8'h77, 2'b11, 1'b1); check("R6", {cout, d}, {1'b1, 8'h00});
      apply(8'h00, 8'h55, 2'b11, 1'b0); check("R7", {cout, d}, {1'b0, 8'hFF});
      apply(8'h01, 8'h55, 2'b11, 1'b0); check("R6", {cout, d}, {1'b1, 8'h00});
   endtask

   initial begin
      a = '0; b = '0; sel = 2'b00; cin = 1'b0;
      #5;
      check("R1", {cout, d}, 9'd0);
      t_add();
      t_sub();
      t_pass_inc();
      t_dec_pass();
      t_random_all_modes();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule